// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the slave side of a small byte-wide non-volatile store reached over a two-wire serial bus. It watches already-synchronised clock (SCL) and data (SDA) lines. It recognises bus start and stop conditions and checks the first byte of every transfer against a fixed device-type pattern and a set of strap inputs. It acknowledges by pulling SDA low through an open-drain enable. Masters can write single bytes or runs of bytes within one page, and can read from a chosen address, from the current address, or as one long sequential burst.

A parameter selects a 256-byte array with 8-byte pages, or a 512-byte array with 16-byte pages. In the larger mode, one device-address bit stands in for the ninth memory address bit. Written bytes are gathered in a page buffer. They reach the array only when a stop ends the write. A self-timed busy period then follows, and during it the slave ignores its own address, so a master can poll for completion. A write-protect input keeps the whole array unchanged.

Top module: `serial_eeprom_slave`

## Requirements
- R1: After reset the slave leaves SDA released, and every array location reads as 8'hFF.
- R2: The slave acknowledges a device-address byte only when bits 7:4 equal 4'b1010 and the strap compare holds. In 256-byte mode, bits 3:1 must equal strap_i[2:0]. In 512-byte mode, bits 3:2 must equal strap_i[2:1] and strap_i[0] has no effect. On a mismatch the slave acknowledges nothing until the next start.
- R3: In 512-byte mode, bit 1 of an acknowledged device-address byte becomes memory address bit 8. Bit 0 selects read (1) or write (0).
- R4: In a write, the byte after the device address sets address bits 7:0. Each later byte is acknowledged and stored at the current address. After each stored byte, only the in-page offset increments (3 bits in 256-byte mode, 4 bits in 512-byte mode), so it wraps within the same page.
- R5: Buffered data reaches the array only at a stop that ends a write holding at least one data byte. A repeated start before the stop discards the bytes. A write with no data bytes changes nothing and starts no busy period.
- R6: A committing stop starts a busy period of WR_CYCLES clocks. During that period the slave does not acknowledge its device address. Once the period ends, it acknowledges again.
- R7: While wp_i is high at the stop, no array location changes and no busy period starts.
- R8: A write-mode device address, then a word address, then a repeated start and a read-mode device address, returns the byte stored at that word address.
- R9: Reads start at the address counter. For a current-address read in 512-byte mode, bit 8 is taken from the device-address byte. The counter advances by one per byte across the whole array and wraps from the top to 0. The slave keeps sending while the master acknowledges, and releases SDA after a master non-acknowledge.
- R10: Read data is sent MSB first. The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Synchronised serial clock line |
| sda_i | input | 1 | Synchronised serial data line |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| strap_i | input | 3 | Hardwired device-address straps |
| wp_i | input | 1 | Write protect: 1 blocks array updates |

## Verification
The bench puts a 512-byte slave and a 256-byte slave on one wired-AND bus and checks both against reference arrays.

It writes runs longer than a page that start near a page end. A design that carried into the page bits would corrupt the next page. It aborts writes with a repeated start, where a slave that wrote through immediately would change the array. It sends zero-data and write-protected writes, where a busy period would show up as a missing acknowledge on the first poll. It reads across the top of the array, where a counter limited to 8 bits or stuck at the top would return the wrong bytes.

Random non-matching device bytes, with the ignored strap bit toggled, catch a loose address compare. An acknowledge to the following byte would show that a slave failed to return to idle after a mismatch.

// File: rtl/eep_pkg.sv
package eep_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_DEV,
        S_DACK,
        S_WADR,
        S_AACK,
        S_WDAT,
        S_WACK,
        S_RDAT,
        S_RACK
    } eep_state_e;

    localparam logic [3:0] DEV_TYPE = 4'b1010;

endpackage

// File: rtl/eep_bus_events.sv
module eep_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    logic scl_d, scl_q;
    logic sda_d, sda_q;

    always_comb begin
        scl_d = scl_i;
        sda_d = sda_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    // data edges while the clock stays high mark bus conditions
    assign scl_rise_o = scl_i & ~scl_q;
    assign scl_fall_o = ~scl_i & scl_q;
    assign start_o    = scl_i & scl_q & sda_q & ~sda_i;
    assign stop_o     = scl_i & scl_q & ~sda_q & sda_i;

endmodule

// File: rtl/eep_write_timer.sv
module eep_write_timer #(
    parameter int WR_CYCLES = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        if (start_i) begin
            cnt_d = CW'(WR_CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end else begin
            cnt_d = cnt_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign busy_o = (cnt_q != '0);

    a_r6_busy_follows_start: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> busy_o);

    a_r6_no_start_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> !start_i);

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int AW = 8,
    parameter int PB = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            ld_i,
    input  logic [PB-1:0]   ld_off_i,
    input  logic [7:0]      ld_data_i,
    input  logic            commit_i,
    input  logic [AW-PB-1:0] page_i,
    input  logic [AW-1:0]   rd_addr_i,
    output logic [7:0]      rd_data_o,
    output logic            pending_o
);

    localparam int DEPTH = 1 << AW;
    localparam int PAGE  = 1 << PB;

    logic [7:0]      mem_q  [DEPTH];
    logic [7:0]      pbuf_d [PAGE];
    logic [7:0]      pbuf_q [PAGE];
    logic [PAGE-1:0] mask_d, mask_q;

    // page staging buffer
    always_comb begin
        mask_d = mask_q;
        for (int i = 0; i < PAGE; i++) begin
            pbuf_d[i] = pbuf_q[i];
        end
        if (clr_i || commit_i) begin
            mask_d = '0;
        end else if (ld_i) begin
            pbuf_d[ld_off_i] = ld_data_i;
            mask_d[ld_off_i] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int i = 0; i < PAGE; i++) begin
                pbuf_q[i] <= 8'h00;
            end
        end else begin
            mask_q <= mask_d;
            for (int i = 0; i < PAGE; i++) begin
                pbuf_q[i] <= pbuf_d[i];
            end
        end
    end

    // array: a commit copies every staged byte into its page slot
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_cell
            localparam int OFF = g % PAGE;
            localparam int PG  = g / PAGE;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    mem_q[g] <= 8'hFF;
                end else if (commit_i && mask_q[OFF] && (page_i == (AW-PB)'(PG))) begin
                    mem_q[g] <= pbuf_q[OFF];
                end
            end
        end
    endgenerate

    assign rd_data_o = mem_q[rd_addr_i];
    assign pending_o = |mask_q;

endmodule

// File: rtl/serial_eeprom_slave.sv
module serial_eeprom_slave
    import eep_pkg::*;
#(
    parameter int BIG_MODE  = 0,
    parameter int WR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic [2:0] strap_i,
    input  logic       wp_i
);

    localparam int AW = (BIG_MODE != 0) ? 9 : 8;
    localparam int PB = (BIG_MODE != 0) ? 4 : 3;

    typedef struct packed {
        eep_state_e    state;
        logic [3:0]    cnt;
        logic [7:0]    shreg;
        logic [AW-1:0] addr;
        logic          oe;
        logic          rd;
        logic          mack;
    } ctl_t;

    ctl_t r_d, r_q;

    logic ev_rise, ev_fall, ev_start, ev_stop;
    logic busy;
    logic buf_clr, buf_ld, buf_commit, buf_pending, wr_start;
    logic [7:0] rd_data;
    logic dev_match;

    eep_bus_events u_events (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (ev_rise),
        .scl_fall_o (ev_fall),
        .start_o    (ev_start),
        .stop_o     (ev_stop)
    );

    eep_write_timer #(.WR_CYCLES(WR_CYCLES)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (wr_start),
        .busy_o  (busy)
    );

    eep_array #(.AW(AW), .PB(PB)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (buf_clr),
        .ld_i      (buf_ld),
        .ld_off_i  (r_q.addr[PB-1:0]),
        .ld_data_i (r_q.shreg),
        .commit_i  (buf_commit),
        .page_i    (r_q.addr[AW-1:PB]),
        .rd_addr_i (r_q.addr),
        .rd_data_o (rd_data),
        .pending_o (buf_pending)
    );

    // device-type and strap compare, one variant per array size
    always_comb begin
        if (BIG_MODE != 0) begin
            dev_match = (r_q.shreg[7:4] == DEV_TYPE) &&
                        (r_q.shreg[3:2] == strap_i[2:1]) && !busy;
        end else begin
            dev_match = (r_q.shreg[7:4] == DEV_TYPE) &&
                        (r_q.shreg[3:1] == strap_i) && !busy;
        end
    end

    always_comb begin
        r_d        = r_q;
        buf_clr    = 1'b0;
        buf_ld     = 1'b0;
        buf_commit = 1'b0;
        wr_start   = 1'b0;

        if (ev_stop) begin
            if (buf_pending) begin
                if (!wp_i) begin
                    buf_commit = 1'b1;
                    wr_start   = 1'b1;
                end else begin
                    buf_clr = 1'b1;
                end
            end
            r_d.state = S_IDLE;
            r_d.oe    = 1'b0;
        end else if (ev_start) begin
            buf_clr   = 1'b1;
            r_d.state = S_DEV;
            r_d.cnt   = 4'd0;
            r_d.oe    = 1'b0;
        end else begin
            unique case (r_q.state)
                S_IDLE: begin
                end

                S_DEV, S_WADR, S_WDAT: begin
                    if (ev_rise && r_q.cnt != 4'd8) begin
                        r_d.shreg = {r_q.shreg[6:0], sda_i};
                        r_d.cnt   = r_q.cnt + 4'd1;
                    end else if (ev_fall && r_q.cnt == 4'd8) begin
                        r_d.cnt = 4'd0;
                        if (r_q.state == S_DEV) begin
                            if (dev_match) begin
                                r_d.oe    = 1'b1;
                                r_d.rd    = r_q.shreg[0];
                                r_d.state = S_DACK;
                                if (BIG_MODE != 0) begin
                                    r_d.addr[AW-1] = r_q.shreg[1];
                                end
                            end else begin
                                r_d.state = S_IDLE;
                            end
                        end else if (r_q.state == S_WADR) begin
                            r_d.addr[7:0] = r_q.shreg;
                            r_d.oe        = 1'b1;
                            r_d.state     = S_AACK;
                        end else begin
                            buf_ld              = 1'b1;
                            r_d.addr[PB-1:0]    = r_q.addr[PB-1:0] + 1'b1;
                            r_d.oe              = 1'b1;
                            r_d.state           = S_WACK;
                        end
                    end
                end

                S_DACK, S_AACK, S_WACK: begin
                    if (ev_fall) begin
                        r_d.oe  = 1'b0;
                        r_d.cnt = 4'd0;
                        if (r_q.state == S_DACK && r_q.rd) begin
                            r_d.shreg = rd_data;
                            r_d.addr  = r_q.addr + 1'b1;
                            r_d.oe    = ~rd_data[7];
                            r_d.state = S_RDAT;
                        end else if (r_q.state == S_DACK) begin
                            r_d.state = S_WADR;
                        end else begin
                            r_d.state = S_WDAT;
                        end
                    end
                end

                S_RDAT: begin
                    if (ev_fall) begin
                        if (r_q.cnt == 4'd7) begin
                            r_d.oe    = 1'b0;
                            r_d.state = S_RACK;
                        end else begin
                            r_d.shreg = {r_q.shreg[6:0], 1'b0};
                            r_d.oe    = ~r_q.shreg[6];
                            r_d.cnt   = r_q.cnt + 4'd1;
                        end
                    end
                end

                S_RACK: begin
                    if (ev_rise) begin
                        r_d.mack = ~sda_i;
                    end else if (ev_fall) begin
                        if (r_q.mack) begin
                            r_d.shreg = rd_data;
                            r_d.addr  = r_q.addr + 1'b1;
                            r_d.oe    = ~rd_data[7];
                            r_d.cnt   = 4'd0;
                            r_d.state = S_RDAT;
                        end else begin
                            r_d.state = S_IDLE;
                        end
                    end
                end

                default: r_d.state = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{state: S_IDLE, cnt: 4'd0, shreg: 8'h00,
                     addr: '0, oe: 1'b0, rd: 1'b0, mack: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe_o = r_q.oe;

    a_r10_sda_moves_on_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

    a_r2_idle_releases_sda: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == S_IDLE) |-> !sda_oe_o);

    a_r4_page_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((r_q.state inside {S_WDAT, S_WACK}) && ($past(r_q.state) inside {S_WDAT, S_WACK}))
        |-> $stable(r_q.addr[AW-1:PB]));

    a_r6_no_ack_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (r_q.state != S_DACK));

endmodule

// File: tb/tb_serial_eeprom_slave.sv
module tb_serial_eeprom_slave;

    localparam int WRC = 300;
    localparam int Q   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic sda_m = 1'b1;
    logic wp = 1'b0;
    logic [2:0] strap_b = 3'b010;
    logic [2:0] strap_s = 3'b000;
    logic oe_b, oe_s;
    logic sda_bus;

    assign sda_bus = sda_m & ~oe_b & ~oe_s;

    always #4 clk = ~clk;

    serial_eeprom_slave #(.BIG_MODE(1), .WR_CYCLES(WRC)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(oe_b), .strap_i(strap_b), .wp_i(wp));

    serial_eeprom_slave #(.BIG_MODE(0), .WR_CYCLES(WRC)) dut_s (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(oe_s), .strap_i(strap_s), .wp_i(wp));

    int vecs = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [7:0] mb [512];
    logic [7:0] ms [256];
    int ptr_b = 0;
    int ptr_s = 0;
    logic [7:0] wbuf [32];

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int amax(input bit sel);
        return sel ? 512 : 256;
    endfunction

    function automatic int psz(input bit sel);
        return sel ? 16 : 8;
    endfunction

    function automatic int page_step(input int a, input int ps);
        return (a & ~(ps - 1)) | ((a + 1) & (ps - 1));
    endfunction

    function automatic logic [7:0] devb(input bit sel, input bit p, input bit rd);
        return sel ? {4'hA, 2'b01, p, rd} : {4'hA, 3'b000, rd};
    endfunction

    function automatic bit hits(input logic [7:0] b);
        return (b[7:4] == 4'hA) && ((b[3:2] == 2'b01) || (b[3:1] == 3'b000));
    endfunction

    function automatic logic [7:0] mget(input bit sel, input int a);
        return sel ? mb[a] : ms[a];
    endfunction

    task automatic qd();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; qd();
        scl = 1'b1; qd();
        sda_m = 1'b0; qd();
        scl = 1'b0; qd();
    endtask

    task automatic bstop();
        sda_m = 1'b0; qd();
        scl = 1'b1; qd();
        sda_m = 1'b1; qd();
    endtask

    task automatic tx(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qd();
            scl = 1'b1; qd(); qd();
            scl = 1'b0; qd();
        end
        sda_m = 1'b1; qd();
        scl = 1'b1; qd();
        ack = ~sda_bus; qd();
        scl = 1'b0; qd();
    endtask

    task automatic rx(input bit give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qd();
            scl = 1'b1; qd();
            b[i] = sda_bus; qd();
            scl = 1'b0;
        end
        qd();
        sda_m = ~give_ack; qd();
        scl = 1'b1; qd(); qd();
        scl = 1'b0; qd();
        sda_m = 1'b1;
    endtask

    task automatic wait_ready(input bit sel, input bit busy);
        bit ack;
        bstart();
        tx(devb(sel, 1'b0, 1'b0), ack);
        bstop();
        if (ack && sel) ptr_b = ptr_b & 255;
        chk(busy ? "R6 poll during write cycle" : "R5/R7 poll with no write cycle",
            int'(ack), int'(!busy));
        for (int k = 0; k < 8 && !ack; k++) begin
            bstart();
            tx(devb(sel, 1'b0, 1'b0), ack);
            bstop();
            if (ack && sel) ptr_b = ptr_b & 255;
        end
        chk("R6 acknowledge after write cycle", int'(ack), 1);
    endtask

    task automatic do_write(input bit sel, input int addr, input int n, input bit dostop);
        bit ack;
        int a;
        int stg [32];
        bstart();
        tx(devb(sel, addr[8], 1'b0), ack);
        chk("R2 write device address ack", int'(ack), 1);
        tx(addr[7:0], ack);
        chk("R4 word address ack", int'(ack), 1);
        a = addr;
        for (int i = 0; i < n; i++) begin
            tx(wbuf[i], ack);
            chk("R4 data byte ack", int'(ack), 1);
            stg[i] = a;
            a = page_step(a, psz(sel));
        end
        if (sel) ptr_b = a; else ptr_s = a;
        if (dostop) begin
            bstop();
            if (!wp && n > 0) begin
                for (int i = 0; i < n; i++) begin
                    if (sel) mb[stg[i]] = wbuf[i]; else ms[stg[i]] = wbuf[i];
                end
            end
            wait_ready(sel, !wp && n > 0);
        end
    endtask

    task automatic do_rread(input bit sel, input int addr, input int n);
        bit ack;
        logic [7:0] b;
        bstart();
        tx(devb(sel, addr[8], 1'b0), ack);
        chk("R8 device address ack", int'(ack), 1);
        tx(addr[7:0], ack);
        chk("R8 word address ack", int'(ack), 1);
        bstart();
        tx(devb(sel, addr[8], 1'b1), ack);
        chk("R8 read device address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            rx(i != n - 1, b);
            chk(i == 0 ? "R8 random read data" : "R9 sequential read data",
                int'(b), int'(mget(sel, (addr + i) % amax(sel))));
        end
        bstop();
        if (sel) ptr_b = (addr + n) % 512; else ptr_s = (addr + n) % 256;
        chk("R9 sda released after master nack", int'(oe_b | oe_s), 0);
    endtask

    task automatic do_cread(input bit sel, input bit p, input int n);
        bit ack;
        logic [7:0] b;
        int a;
        a = sel ? ((int'(p) << 8) | (ptr_b & 255)) : ptr_s;
        bstart();
        tx(devb(sel, p, 1'b1), ack);
        chk("R3 current read device address ack", int'(ack), 1);
        for (int i = 0; i < n; i++) begin
            rx(i != n - 1, b);
            chk("R9 current-address read data", int'(b),
                int'(mget(sel, (a + i) % amax(sel))));
        end
        bstop();
        if (sel) ptr_b = (a + n) % 512; else ptr_s = (a + n) % 256;
    endtask

    task automatic do_bad();
        bit ack;
        logic [7:0] b;
        b = 8'($urandom());
        while (hits(b)) b = 8'($urandom());
        bstart();
        tx(b, ack);
        chk("R2 mismatched device address nack", int'(ack), 0);
        tx(8'h00, ack);
        chk("R2 ignored until next start", int'(ack), 0);
        bstop();
    endtask

    task automatic fill(input int n);
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom());
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 512; i++) mb[i] = 8'hFF;
        for (int i = 0; i < 256; i++) ms[i] = 8'hFF;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk("R1 sda released after reset", int'(oe_b | oe_s), 0);
        do_rread(1'b0, 8'h10, 2);
        do_cread(1'b1, 1'b1, 2);

        // R4 page wrap in the upper half of the large array (R3 address bit 8)
        fill(20);
        do_write(1'b1, 9'h1FC, 20, 1'b1);
        do_rread(1'b1, 9'h1F0, 16);
        do_rread(1'b1, 9'h0F0, 2);

        // R4 small page wrap
        fill(11);
        do_write(1'b0, 8'h45, 11, 1'b1);
        do_rread(1'b0, 8'h40, 8);

        // R5 aborted write by repeated start
        fill(3);
        do_write(1'b0, 8'h20, 3, 1'b0);
        do_rread(1'b0, 8'h20, 3);

        // R5 zero data write
        do_write(1'b0, 8'h33, 0, 1'b1);

        // R7 write protect
        wp = 1'b1;
        fill(4);
        do_write(1'b1, 9'h040, 4, 1'b1);
        wp = 1'b0;
        do_rread(1'b1, 9'h040, 4);

        // R9 wrap at the top of each array
        fill(2);
        do_write(1'b1, 9'h1FF, 1, 1'b1);
        do_rread(1'b1, 9'h1FE, 4);
        do_rread(1'b0, 8'hFE, 4);

        // R2 mismatches, with the ignored strap bit flipped
        strap_b[0] = 1'b1;
        do_bad();
        do_bad();
        do_cread(1'b1, 1'b0, 3);
        strap_b[0] = 1'b0;

        // constrained random mix
        for (int it = 0; it < 24; it++) begin
            bit sel;
            int op;
            int a;
            int n;
            sel = 1'($urandom());
            op = $urandom_range(0, 5);
            a = $urandom_range(0, amax(sel) - 1);
            strap_b[0] = 1'($urandom());
            case (op)
                0, 1: begin
                    n = $urandom_range(1, psz(sel) + 3);
                    fill(n);
                    wp = ($urandom_range(0, 3) == 0);
                    do_write(sel, a, n, 1'b1);
                    wp = 1'b0;
                end
                2: begin
                    n = $urandom_range(1, 4);
                    fill(n);
                    do_write(sel, a, n, 1'b0);
                end
                3: do_rread(sel, a, $urandom_range(1, 12));
                4: do_cread(sel, 1'($urandom()), $urandom_range(1, 6));
                default: do_bad();
            endcase
        end
        bstop();

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, fails);
        $finish;
    end

endmodule